// File: doc/BRIEF.md
# SPI Transfer Engine

This block shifts one serial word at a time over an SPI link. It can act as the master or as a slave. A 16-bit control word configures it. The control word selects the role, the resting level of SCK, which SCK edge samples data, a 4-bit word-length code and an 8-bit baud divisor.

As master, a one-cycle start pulse captures the transmit word and the current configuration. The block then generates SCK from the system clock and shifts the word out MSB first while it shifts the reply in. A per-transfer flag picks the word length: either the coded length, or a fixed 8 bits.

As slave, the block synchronizes an external SCK, data-in line and active-low select into the system clock domain. It follows the external edges and stores a word each time the coded number of bits has arrived. The system clock must run at least four times faster than SCK. A master-to-slave round trip with this block on both sides needs a divisor of at least 4, so that the slave's reply settles before the master samples it.

Top module: `spi_xfer_engine`

## Requirements
- R1: Control word fields are as follows.
  - Bits [7:0]: divisor D.
  - Bits [11:8]: length code.
  - Bit 12: CPHA.
  - Bit 13: CPOL.
  - Bit 14: role, where 1 means master and 0 means slave.
  - Bit 15: ignored.
  
  In master mode a start pulse while idle makes busy rise on the next cycle.
- R2: Length code decoding: codes 8 to 15 mean that many bits, code 0 means 16 bits, and codes 1 to 7 mean 8 bits. With the per-transfer flag set, a master transfer makes exactly 2·n SCK transitions.
- R3: In master mode with the per-transfer flag clear, exactly 8 bits are shifted whatever the length code holds.
- R4: Data is shifted MSB first. The received word appears in the low n bits of rx_data_o, and the upper bits are zero.
- R5: While idle, SCK rests at CPOL (0 = low, 1 = high). It is back at CPOL when a master transfer completes.
- R6: With CPHA=0, data is sampled on the leading SCK edge and the data line changes only on trailing edges. With CPHA=1, the data line changes on leading edges and data is sampled on trailing edges.
- R7: Each SCK half period lasts D system cycles, with D values 0 and 1 treated as 2. The first SCK transition comes D cycles after the start edge. The whole master transfer takes 2·n·D cycles.
- R8: busy stays high from the cycle after start until the final SCK edge. done pulses for one cycle as busy falls, and rx_data_o is valid in that cycle. A start while busy is ignored.
- R9: In slave mode, with select low, the block receives n bits (n from the length code) on external SCK edges, stores them and pulses done. It returns the word captured when select fell, on miso_o.
- R10: In slave mode start_i is ignored: busy stays low while select is high, and sck_o holds CPOL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 16 | Control word |
| start_i | input | 1 | Master start pulse |
| len_en_i | input | 1 | Per-transfer flag: 1 uses length code, 0 forces 8 bits |
| tx_data_i | input | 16 | Word to transmit, right-justified |
| rx_data_o | output | 16 | Last received word, right-justified |
| busy_o | output | 1 | Transfer in progress (slave: selected) |
| done_o | output | 1 | One-cycle completion pulse |
| sck_o | output | 1 | Master serial clock |
| mosi_o | output | 1 | Master data out |
| miso_i | input | 1 | Master data in |
| sck_i | input | 1 | Slave serial clock in |
| mosi_i | input | 1 | Slave data in |
| ss_ni | input | 1 | Slave select, active low |
| miso_o | output | 1 | Slave data out |

## Verification
Master timing is fixed in cycles after the sampling edge that takes start. busy is high one cycle later. The first SCK change lands D cycles later, and done, together with a valid rx_data_o, lands exactly 2·n·D cycles later. The bench counts falling-edge samples from the start edge and checks each of these at its exact count. It also checks that the data line moves only on the non-sampling SCK transitions. In slave mode done trails the master's final sampling edge by the synchronizer latency, so the bench catches the slave's done pulse in any cycle of a bounded window rather than at a fixed count.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
  localparam int WORD_W = 16;
  localparam int CNT_W  = $clog2(WORD_W) + 1;
  localparam int EDGE_W = CNT_W + 1;
  localparam int DIV_W  = 8;
  localparam int LEN_W  = 4;
  localparam int MIN_DIV = 2;

  typedef struct packed {
    logic             spare;
    logic             master;
    logic             cpol;
    logic             cpha;
    logic [LEN_W-1:0] len_code;
    logic [DIV_W-1:0] div;
  } ctrl_t;

  function automatic logic [CNT_W-1:0] len_decode(input logic [LEN_W-1:0] code);
    if (code == '0) return CNT_W'(WORD_W);
    if (code[LEN_W-1]) return CNT_W'(code);
    return CNT_W'(8);
  endfunction

  function automatic logic [DIV_W-1:0] div_clamp(input logic [DIV_W-1:0] d);
    return (d < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : d;
  endfunction

  // place bit n-1 of the word at the MSB of the shifter
  function automatic logic [WORD_W-1:0] align_msb(input logic [WORD_W-1:0] w,
                                                   input logic [CNT_W-1:0] n);
    return w << (CNT_W'(WORD_W) - n);
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= {STAGES{RST_VAL}};
    else         stage_q <= {stage_q[STAGES-2:0], d_i};
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  assign wrap   = (cnt_q == div_i - DIV_W'(1));
  assign tick_o = run_i & wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i || !run_i) cnt_q <= '0;
    else if (wrap)           cnt_q <= '0;
    else                     cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/spi_master_core.sv
module spi_master_core
  import spi_xfer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              start_i,
  input  logic              len_en_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic [LEN_W-1:0]  len_code_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              sck_o,
  output logic              mosi_o
);
  logic              busy_q, done_q, cpol_q, cpha_q, sck_q, mosi_q;
  logic [DIV_W-1:0]  div_q;
  logic [CNT_W-1:0]  nbits_q, len_sel;
  logic [EDGE_W-1:0] edge_q, last_edge;
  logic [WORD_W-1:0] tx_q, rx_q, rx_data_q, rx_next, tx_aligned;
  logic              tick, start_ok, lead_ev, trail_ev, sample_ev, launch_ev, last_ev;

  assign len_sel    = len_en_i ? len_decode(len_code_i) : CNT_W'(8);
  assign tx_aligned = align_msb(tx_data_i, len_sel);
  assign start_ok   = en_i & start_i & ~busy_q;

  spi_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_q),
    .clr_i  (start_ok),
    .div_i  (div_q),
    .tick_o (tick)
  );

  assign last_edge = {nbits_q, 1'b0} - EDGE_W'(1);
  assign lead_ev   = tick & ~edge_q[0];
  assign trail_ev  = tick &  edge_q[0];
  assign sample_ev = cpha_q ? trail_ev : lead_ev;
  assign launch_ev = cpha_q ? lead_ev  : trail_ev;
  assign last_ev   = tick & (edge_q == last_edge);
  assign rx_next   = {rx_q[WORD_W-2:0], miso_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      cpol_q    <= 1'b0;
      cpha_q    <= 1'b0;
      sck_q     <= 1'b0;
      mosi_q    <= 1'b0;
      div_q     <= DIV_W'(MIN_DIV);
      nbits_q   <= CNT_W'(8);
      edge_q    <= '0;
      tx_q      <= '0;
      rx_q      <= '0;
      rx_data_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_ok) begin
        busy_q  <= 1'b1;
        cpol_q  <= cpol_i;
        cpha_q  <= cpha_i;
        sck_q   <= cpol_i;
        div_q   <= div_i;
        nbits_q <= len_sel;
        edge_q  <= '0;
        rx_q    <= '0;
        if (!cpha_i) begin
          // first bit must be valid before the leading edge
          mosi_q <= tx_aligned[WORD_W-1];
          tx_q   <= tx_aligned << 1;
        end else begin
          tx_q   <= tx_aligned;
        end
      end else if (busy_q && tick) begin
        sck_q  <= ~sck_q;
        edge_q <= edge_q + EDGE_W'(1);
        if (sample_ev) rx_q <= rx_next;
        if (launch_ev) begin
          mosi_q <= tx_q[WORD_W-1];
          tx_q   <= tx_q << 1;
        end
        if (last_ev) begin
          busy_q    <= 1'b0;
          done_q    <= 1'b1;
          rx_data_q <= sample_ev ? rx_next : rx_q;
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign rx_data_o = rx_data_q;
  assign sck_o     = busy_q ? sck_q : cpol_i;
  assign mosi_o    = mosi_q;
endmodule

// File: rtl/spi_slave_core.sv
module spi_slave_core
  import spi_xfer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic [LEN_W-1:0]  len_code_i,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              ss_ni,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              miso_o
);
  logic [2:0]        sync_q;
  logic              ss_s, sck_s, mosi_s;
  logic              sck_d, sel, sel_d, sel_rise;
  logic              lead_ev, trail_ev, sample_ev, launch_ev;
  logic              done_q, miso_q;
  logic [CNT_W-1:0]  nbits, bit_q;
  logic [WORD_W-1:0] tx_q, rx_q, rx_data_q, rx_next, tx_aligned;

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({ss_ni, sck_i, mosi_i}),
    .q_o    (sync_q)
  );
  assign {ss_s, sck_s, mosi_s} = sync_q;

  assign nbits      = len_decode(len_code_i);
  assign tx_aligned = align_msb(tx_data_i, nbits);
  assign sel        = en_i & ~ss_s;
  assign sel_rise   = sel & ~sel_d;
  assign lead_ev    = sel & ~sel_rise & (sck_s != sck_d) & (sck_d == cpol_i);
  assign trail_ev   = sel & ~sel_rise & (sck_s != sck_d) & (sck_d != cpol_i);
  assign sample_ev  = cpha_i ? trail_ev : lead_ev;
  assign launch_ev  = cpha_i ? lead_ev  : trail_ev;
  assign rx_next    = {rx_q[WORD_W-2:0], mosi_s};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d     <= 1'b0;
      sel_d     <= 1'b0;
      done_q    <= 1'b0;
      miso_q    <= 1'b0;
      bit_q     <= '0;
      tx_q      <= '0;
      rx_q      <= '0;
      rx_data_q <= '0;
    end else begin
      sck_d  <= sck_s;
      sel_d  <= sel;
      done_q <= 1'b0;
      if (!sel) begin
        bit_q <= '0;
        rx_q  <= '0;
      end else if (sel_rise) begin
        bit_q <= '0;
        rx_q  <= '0;
        if (!cpha_i) begin
          miso_q <= tx_aligned[WORD_W-1];
          tx_q   <= tx_aligned << 1;
        end else begin
          tx_q   <= tx_aligned;
        end
      end else begin
        if (launch_ev) begin
          miso_q <= tx_q[WORD_W-1];
          tx_q   <= tx_q << 1;
        end
        if (sample_ev) begin
          if (bit_q == nbits - CNT_W'(1)) begin
            rx_data_q <= rx_next;
            done_q    <= 1'b1;
            bit_q     <= '0;
            rx_q      <= '0;
          end else begin
            rx_q  <= rx_next;
            bit_q <= bit_q + CNT_W'(1);
          end
        end
      end
    end
  end

  assign busy_o    = sel;
  assign done_o    = done_q;
  assign rx_data_o = rx_data_q;
  assign miso_o    = miso_q;
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_xfer_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] ctrl_i,
  input  logic        start_i,
  input  logic        len_en_i,
  input  logic [15:0] tx_data_i,
  output logic [15:0] rx_data_o,
  output logic        busy_o,
  output logic        done_o,
  output logic        sck_o,
  output logic        mosi_o,
  input  logic        miso_i,
  input  logic        sck_i,
  input  logic        mosi_i,
  input  logic        ss_ni,
  output logic        miso_o
);
  ctrl_t             ctrl;
  logic              is_master, ctrl_unused;
  logic              m_busy, m_done, m_sck;
  logic              s_busy, s_done;
  logic [WORD_W-1:0] m_rx, s_rx;

  assign ctrl        = ctrl_t'(ctrl_i);
  assign is_master   = ctrl.master;
  assign ctrl_unused = ctrl.spare;

  spi_master_core u_master (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (is_master),
    .start_i    (start_i),
    .len_en_i   (len_en_i),
    .cpol_i     (ctrl.cpol),
    .cpha_i     (ctrl.cpha),
    .len_code_i (ctrl.len_code),
    .div_i      (div_clamp(ctrl.div)),
    .tx_data_i  (tx_data_i),
    .miso_i     (miso_i),
    .busy_o     (m_busy),
    .done_o     (m_done),
    .rx_data_o  (m_rx),
    .sck_o      (m_sck),
    .mosi_o     (mosi_o)
  );

  spi_slave_core #(.SYNC_STAGES(2)) u_slave (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (~is_master),
    .cpol_i     (ctrl.cpol),
    .cpha_i     (ctrl.cpha),
    .len_code_i (ctrl.len_code),
    .tx_data_i  (tx_data_i),
    .sck_i      (sck_i),
    .mosi_i     (mosi_i),
    .ss_ni      (ss_ni),
    .busy_o     (s_busy),
    .done_o     (s_done),
    .rx_data_o  (s_rx),
    .miso_o     (miso_o)
  );

  assign busy_o    = is_master ? m_busy : s_busy;
  assign done_o    = is_master ? m_done : s_done;
  assign rx_data_o = is_master ? m_rx   : s_rx;
  assign sck_o     = is_master ? m_sck  : ctrl.cpol;
endmodule

// File: rtl/spi_xfer_engine_chk.sv
module spi_xfer_engine_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] ctrl_i,
  input logic        start_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        sck_o
);
  // R8: done is a single-cycle pulse
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R5: idle master rests SCK at CPOL
  assert_idle_level_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[14] && !busy_o) |-> (sck_o == ctrl_i[13]));

  // R7: a half period is never shorter than two cycles
  assert_half_period_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && ctrl_i[14] && sck_o != $past(sck_o) && $stable(ctrl_i))
      |=> (!$stable(ctrl_i) || sck_o == $past(sck_o)));

  // R8: master busy only falls together with done
  assert_busy_fall_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[14] && $stable(ctrl_i[14]) && $fell(busy_o)) |-> done_o);

  // R1: idle master accepts start on the next cycle
  assert_start_busy_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[14] && start_i && !busy_o) |=> (busy_o || !ctrl_i[14]));
endmodule

bind spi_xfer_engine spi_xfer_engine_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ctrl_i  (ctrl_i),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .sck_o   (sck_o)
);

// File: tb/spi_xfer_engine_tb_top.sv
module spi_xfer_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ctrl = 16'h4000;
  logic        start = 1'b0;
  logic        len_en = 1'b1;
  logic [15:0] tx_data = '0;
  logic        dut_ss = 1'b1;
  logic        use_pair = 1'b0;
  logic [15:0] s_ctrl = 16'h0000;
  logic [15:0] s_tx = '0;
  logic        s_ss = 1'b1;

  logic [15:0] rx_data, s_rx;
  logic        busy, done, sck, mosi, dut_miso_o;
  logic        s_busy, s_done, s_sck, s_mosi, s_miso;
  logic        miso_in;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  assign miso_in = use_pair ? s_miso : mosi;

  spi_xfer_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_i(ctrl), .start_i(start), .len_en_i(len_en),
    .tx_data_i(tx_data), .rx_data_o(rx_data), .busy_o(busy), .done_o(done),
    .sck_o(sck), .mosi_o(mosi), .miso_i(miso_in), .sck_i(1'b0), .mosi_i(1'b0),
    .ss_ni(dut_ss), .miso_o(dut_miso_o)
  );

  spi_xfer_engine slave_i (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_i(s_ctrl), .start_i(1'b0), .len_en_i(1'b0),
    .tx_data_i(s_tx), .rx_data_o(s_rx), .busy_o(s_busy), .done_o(s_done),
    .sck_o(s_sck), .mosi_o(s_mosi), .miso_i(1'b0), .sck_i(sck), .mosi_i(mosi),
    .ss_ni(s_ss), .miso_o(s_miso)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int exp_len(input logic [3:0] code, input bit en);
    if (!en) return 8;
    if (code == 4'd0) return 16;
    if (code >= 4'd8) return int'(code);
    return 8;
  endfunction

  function automatic logic [15:0] mask_of(input int n);
    logic [31:0] m;
    m = (32'd1 << n) - 32'd1;
    return m[15:0];
  endfunction

  task automatic run_xfer(input bit cpol, input bit cpha, input logic [3:0] code,
                          input bit en, input logic [7:0] div, input logic [15:0] tx,
                          input bit pair, input logic [15:0] stx, input bit poke);
    int n, d, t, cyc, first, togg, viol;
    bit lead, samp, s_seen;
    logic ps, pm;
    logic [15:0] s_cap, exp_rx;
    string lreq;
    n = exp_len(code, en);
    d = (div < 8'd2) ? 2 : int'(div);
    t = 2 * n * d;
    lreq = en ? "R2" : "R3";
    @(negedge clk);
    ctrl = {1'b1, 1'b1, cpol, cpha, code, div};
    tx_data = tx;
    len_en = en;
    use_pair = pair;
    s_seen = 1'b0;
    s_cap = '0;
    if (pair) begin
      s_ctrl = {1'b0, 1'b0, cpol, cpha, code, div};
      s_tx = stx;
      s_ss = 1'b0;
      repeat (6) @(negedge clk);
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R1 busy after start", {31'd0, busy}, 32'd1);
    cyc = 0; first = -1; togg = 0; viol = 0;
    ps = sck; pm = mosi;
    while (!done && cyc < t + 50) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 5) begin start = 1'b1; tx_data = ~tx; end
      if (poke && cyc == 6) start = 1'b0;
      if (sck !== ps) begin
        togg++;
        if (first < 0) first = cyc;
        lead = (togg % 2) == 1;
        samp = cpha ? !lead : lead;
        if (mosi !== pm && samp) viol++;
      end else if (mosi !== pm) viol++;
      ps = sck; pm = mosi;
      if (s_done) begin s_seen = 1'b1; s_cap = s_rx; end
    end
    exp_rx = (pair ? stx : tx) & mask_of(n);
    chk("R7 transfer cycles", cyc, t);
    chk("R7 first half period", first, d);
    chk({lreq, " SCK transitions"}, togg, 2 * n);
    chk("R6 data changes on launch edges only", viol, 0);
    chk("R4 rx word", {16'd0, rx_data}, {16'd0, exp_rx});
    chk("R8 busy low with done", {31'd0, busy}, 32'd0);
    chk("R5 SCK idle after transfer", {31'd0, sck}, {31'd0, cpol});
    @(negedge clk);
    chk("R8 done one cycle", {31'd0, done}, 32'd0);
    if (pair) begin
      for (int k = 0; k < 10 && !s_seen; k++) begin
        if (s_done) begin s_seen = 1'b1; s_cap = s_rx; end
        @(negedge clk);
      end
      chk("R9 slave done seen", {31'd0, s_seen}, 32'd1);
      chk("R9 slave rx word", {16'd0, s_cap}, {16'd0, tx & mask_of(n)});
      s_ss = 1'b1;
      repeat (4) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 reset busy", {31'd0, busy}, 32'd0);
    chk("R8 reset done", {31'd0, done}, 32'd0);
    chk("R5 reset SCK idle", {31'd0, sck}, 32'd0);
    chk("R4 reset rx", {16'd0, rx_data}, 32'd0);

    // loopback sweep over modes, codes and small divisors
    for (int m = 0; m < 4; m++)
      for (int c = 0; c < 16; c++)
        run_xfer(m[1], m[0], c[3:0], 1'b1, 8'(c % 4),
                 16'hA5C3 ^ 16'(c * 16'h1357) ^ {m[3:0], 12'h000}, 1'b0, 16'h0, 1'b0);

    // per-transfer flag clear forces 8 bits (R3)
    for (int m = 0; m < 4; m++) begin
      run_xfer(m[1], m[0], 4'h0, 1'b0, 8'd3, 16'hF00F ^ 16'(m), 1'b0, 16'h0, 1'b0);
      run_xfer(m[1], m[0], 4'hC, 1'b0, 8'd1, 16'h3CA5 ^ 16'(m), 1'b0, 16'h0, 1'b0);
    end

    // start while busy ignored (R8)
    run_xfer(1'b0, 1'b0, 4'hA, 1'b1, 8'd2, 16'h02D7, 1'b0, 16'h0, 1'b1);

    // master to slave pairs (R9)
    for (int m = 0; m < 4; m++) begin
      run_xfer(m[1], m[0], 4'h0, 1'b1, 8'd4, 16'hC3A5 ^ 16'(m), 1'b1, 16'h5E71, 1'b0);
      run_xfer(m[1], m[0], 4'h9, 1'b1, 8'd5, 16'h01B6, 1'b1, 16'h0135 ^ 16'(m), 1'b0);
      run_xfer(m[1], m[0], 4'h4, 1'b1, 8'd7, 16'h00E2, 1'b1, 16'h009D, 1'b0);
      run_xfer(m[1], m[0], 4'hF, 1'b1, 8'd4, 16'h6D2B, 1'b1, 16'h1F0E, 1'b0);
    end

    // large divisor
    run_xfer(1'b1, 1'b1, 4'hB, 1'b1, 8'd200, 16'h0555, 1'b0, 16'h0, 1'b0);

    // slave mode ignores start (R10)
    @(negedge clk);
    ctrl = 16'h2000 | 16'h0802;
    dut_ss = 1'b1;
    repeat (4) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (busy !== 1'b0 || done !== 1'b0 || sck !== 1'b1) begin
        chk("R10 slave idle", {29'd0, busy, done, sck}, 32'd1);
        break;
      end
    end
    chk("R10 slave busy low", {31'd0, busy}, 32'd0);
    chk("R10 slave SCK at CPOL", {31'd0, sck}, 32'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule